// File: doc/BRIEF.md
# Saw-Wave PWM Timer Channel

This block is one timer channel that produces two pulse-width-modulated outputs from a single up-counter. The counter advances once per prescaled clock tick. It returns to zero after it reaches a programmable cycle value, so a cycle value of N gives a period of N+1 ticks. Each output has its own compare value and a 5-bit pin function code. The code gives the level the output takes when counting starts, the action taken at the cycle end, and the action taken on a compare match. An output can also be forced to constant 0% or 100% duty. Each output has an enable, and a separate level is driven whenever the counter is stopped.

Software configures the channel through a simple write port with a 4-bit address. The address map is: 0 protection, 1 command, 2 control, 3 cycle, 4 compare A, 5 compare B, 6 pin control, 7 duty override, 8 status. Three sticky flags report compare matches and the cycle-end wrap. A key-guarded protection bit freezes the configuration. The channel runs either as a free-running saw-wave PWM or as a one-shot that runs a single cycle and halts.

Top module: `ptm_saw_timer`

## Requirements
- R1: After reset the counter is stopped at 0, both outputs read 0 with their enables low, all status flags are 0 and write protection is off.
- R2: Control bits [10:8] hold the prescale code. Codes 0..5 divide the clock by 1, 4, 16, 64, 256 and 1024, and codes 6 and 7 also divide by 1024. The counter steps once per prescaled tick.
- R3: A pin function code has three fields. Bit 4 is the level loaded at start. Bits [3:2] are the cycle-end action and bits [1:0] the compare-match action, with actions 0 hold, 1 low, 2 high, 3 toggle. If both events fall on the same tick, the cycle-end action wins. So with cycle N and compare C, code 0x06 is high for N−C ticks per period and code 0x19 is high for C+1 ticks.
- R4: Duty override bits [1:0] (output A) and [3:2] (output B) select 0 or 1 = follow the compare logic, 2 = constant low, 3 = constant high while running.
- R5: Pin control bits [6:0] apply to output A and bits [14:8] to output B. Each group holds the function code in [4:0], the stop level in [5] and the enable in [6]. A disabled output reads 0. An enabled output drives its stop level whenever the counter is stopped.
- R6: With cycle value N the counter counts 0..N and returns to 0, giving a period of N+1 ticks. The overflow flag is set on that wrap.
- R7: Status bit 0 is the compare-A match flag, bit 1 the compare-B match flag and bit 2 the overflow flag. The flags are sticky. Writing 0 to a status bit clears it and writing 1 leaves it unchanged. A new event in the same cycle as a clear wins.
- R8: Protection register bit 0 is the write-protect bit. It changes only when data bits [15:8] equal 0xA5. While it is set, writes to control, cycle, compare, pin control and duty are ignored, but command and status writes still act.
- R9: With control bit 4 set (one-shot), the counter halts at the first cycle end, rests at 0 and the outputs fall back to their stop levels.
- R10: Cycle and compare values written while running take effect only at the next cycle end. Values written while stopped take effect on the following clock.
- R11: Control bit 0 runs or halts the counter. Command bit 0 starts it, bit 1 stops it (stop wins over start) and bit 2 clears the count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Register write data |
| out_a | output | 1 | Output A level |
| out_b | output | 1 | Output B level |
| oe_a | output | 1 | Output A enable |
| oe_b | output | 1 | Output B enable |
| count_o | output | CNT_W | Current counter value |
| running_o | output | 1 | Counter is running |
| flag_cmp_a | output | 1 | Sticky compare-A match flag |
| flag_cmp_b | output | 1 | Sticky compare-B match flag |
| flag_ovf | output | 1 | Sticky cycle-end wrap flag |

## Verification
On every cycle the assertions check the following. A cycle-end tick always returns the count to 0 and raises the overflow flag. Flags never drop without a status write. A protected cycle write leaves the stored value untouched. A one-shot cycle end halts the counter. The cycle-end and match actions always leave the output state at the level the function code asks for. Only the bench scenarios can show the whole-period behaviour: the measured high time per period for each pin function code, the period length per prescale code, the deferral of a cycle change to the next wrap, and the effect of overrides and stop levels seen at the pins.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

    localparam int ADDR_W = 4;
    localparam int N_OUT  = 2;

    localparam logic [ADDR_W-1:0] A_PROT  = 4'd0;
    localparam logic [ADDR_W-1:0] A_CMD   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd2;
    localparam logic [ADDR_W-1:0] A_CYCLE = 4'd3;
    localparam logic [ADDR_W-1:0] A_CMPA  = 4'd4;
    localparam logic [ADDR_W-1:0] A_IOCTL = 4'd6;
    localparam logic [ADDR_W-1:0] A_DUTY  = 4'd7;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd8;

    localparam logic [7:0] PROT_KEY = 8'hA5;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    typedef enum logic [1:0] {
        DUTY_CMP  = 2'd0,
        DUTY_RSV  = 2'd1,
        DUTY_ZERO = 2'd2,
        DUTY_FULL = 2'd3
    } duty_e;

    typedef struct packed {
        logic       oe;
        logic       stop_lvl;
        logic [4:0] func;
    } chan_io_t;

    // Terminal value of the prescale counter for a given code.
    function automatic logic [15:0] presc_limit(input logic [2:0] code);
        if (code > 3'd5) return 16'd1023;
        return (16'd1 << (2 * code)) - 16'd1;
    endfunction

endpackage

// File: rtl/ptm_prescaler.sv
module ptm_prescaler
    import ptm_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic [2:0] code,
    output logic       tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = DIV_W'(presc_limit(code));
        tick  = run && (pre_q.cnt == lim);
        pre_d = pre_q;
        if (!run || clr || tick) pre_d.cnt = '0;
        else                     pre_d.cnt = pre_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2: a tick is never followed directly by another tick unless dividing by 1
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim != '0 && $stable(code) && !clr) |=> !tick);

endmodule

// File: rtl/ptm_wave.sv
module ptm_wave
    import ptm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_evt,
    input  logic     end_evt,
    input  logic     match_evt,
    input  logic     running,
    input  chan_io_t io,
    input  logic [1:0] duty,
    output logic     pin,
    output logic     pin_oe
);

    typedef struct packed {
        logic lvl;
    } wave_t;

    wave_t w_d, w_q;

    function automatic logic apply_act(input logic [1:0] act, input logic cur);
        case (pin_act_e'(act))
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

    always_comb begin
        w_d = w_q;
        if (start_evt)      w_d.lvl = io.func[4];
        else if (end_evt)   w_d.lvl = apply_act(io.func[3:2], w_q.lvl);
        else if (match_evt) w_d.lvl = apply_act(io.func[1:0], w_q.lvl);

        pin_oe = io.oe;
        if (!io.oe)        pin = 1'b0;
        else if (!running) pin = io.stop_lvl;
        else begin
            case (duty_e'(duty))
                DUTY_ZERO: pin = 1'b0;
                DUTY_FULL: pin = 1'b1;
                default:   pin = w_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    // R3: cycle-end action "low" leaves the output state low
    a_r3_end_low: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && !start_evt && io.func[3:2] == 2'(ACT_LOW)) |=> !w_q.lvl);

    // R3: a lone compare match with action "high" leaves the output state high
    a_r3_match_high: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && !end_evt && !start_evt && io.func[1:0] == 2'(ACT_HIGH)) |=> w_q.lvl);

endmodule

// File: rtl/ptm_saw_timer.sv
module ptm_saw_timer
    import ptm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             out_a,
    output logic             out_b,
    output logic             oe_a,
    output logic             oe_b,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             flag_cmp_a,
    output logic             flag_cmp_b,
    output logic             flag_ovf
);

    localparam int FLG_W = N_OUT + 1;

    typedef struct packed {
        logic                        run;
        logic                        wp;
        logic                        one_shot;
        logic [2:0]                  presc;
        logic [CNT_W-1:0]            cnt;
        logic [CNT_W-1:0]            cyc_sh;
        logic [CNT_W-1:0]            cyc_act;
        logic [N_OUT-1:0][CNT_W-1:0] cmp_sh;
        logic [N_OUT-1:0][CNT_W-1:0] cmp_act;
        chan_io_t [N_OUT-1:0]        io;
        logic [N_OUT-1:0][1:0]       duty;
        logic [FLG_W-1:0]            flg;
    } tmr_t;

    tmr_t q, d;

    logic             tick, cyc_end, cmd_wr, cmd_clr, open_wr, start_evt;
    logic [N_OUT-1:0] match, pin, pin_oe;
    logic [FLG_W-1:0] flg_set;

    ptm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.run),
        .clr  (cmd_clr),
        .code (q.presc),
        .tick (tick)
    );

    always_comb begin
        d       = q;
        cmd_wr  = wr_en && (wr_addr == A_CMD);
        cmd_clr = cmd_wr && wr_data[2];
        open_wr = wr_en && !q.wp;
        cyc_end = tick && (q.cnt == q.cyc_act);
        for (int i = 0; i < N_OUT; i++) match[i] = tick && (q.cnt == q.cmp_act[i]);
        flg_set = {cyc_end, match};

        // counter and one-shot halt
        if (cyc_end) begin
            d.cnt = '0;
            if (q.one_shot) d.run = 1'b0;
        end else if (tick) begin
            d.cnt = q.cnt + 1'b1;
        end

        // active values follow the shadows at a wrap or while halted
        if (!q.run || cyc_end) begin
            d.cyc_act = q.cyc_sh;
            d.cmp_act = q.cmp_sh;
        end

        // register writes
        if (wr_en && wr_addr == A_PROT && wr_data[15:8] == PROT_KEY) d.wp = wr_data[0];
        if (open_wr && wr_addr == A_CTRL) begin
            d.run      = wr_data[0];
            d.one_shot = wr_data[4];
            d.presc    = wr_data[10:8];
        end
        if (open_wr && wr_addr == A_CYCLE) d.cyc_sh = wr_data;
        for (int i = 0; i < N_OUT; i++) begin
            if (open_wr && wr_addr == A_CMPA + 4'(i)) d.cmp_sh[i] = wr_data;
            if (open_wr && wr_addr == A_IOCTL)        d.io[i]     = chan_io_t'(wr_data[8*i +: 7]);
            if (open_wr && wr_addr == A_DUTY)         d.duty[i]   = wr_data[2*i +: 2];
        end
        if (wr_en && wr_addr == A_STAT) d.flg = q.flg & wr_data[FLG_W-1:0];
        d.flg = d.flg | flg_set;

        // software commands
        if (cmd_wr) begin
            if (wr_data[2]) d.cnt = '0;
            if (wr_data[0]) d.run = 1'b1;
            if (wr_data[1]) d.run = 1'b0;
        end

        start_evt = d.run && !q.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        ptm_wave u_wave (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_evt(start_evt),
            .end_evt  (cyc_end),
            .match_evt(match[g]),
            .running  (q.run),
            .io       (q.io[g]),
            .duty     (q.duty[g]),
            .pin      (pin[g]),
            .pin_oe   (pin_oe[g])
        );
    end

    assign out_a      = pin[0];
    assign out_b      = pin[1];
    assign oe_a       = pin_oe[0];
    assign oe_b       = pin_oe[1];
    assign count_o    = q.cnt;
    assign running_o  = q.run;
    assign flag_cmp_a = q.flg[0];
    assign flag_cmp_b = q.flg[1];
    assign flag_ovf   = q.flg[FLG_W-1];

    // R6: a cycle-end tick returns the count to 0 and raises overflow
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && tick && q.cnt == q.cyc_act && !wr_en) |=> (q.cnt == '0 && flag_ovf));

    // R7: a flag holds until a status write
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_cmp_a && !(wr_en && wr_addr == A_STAT)) |=> flag_cmp_a);

    // R8: a protected cycle write leaves the stored cycle unchanged
    a_r8_protect: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wp && wr_en && wr_addr == A_CYCLE) |=> $stable(q.cyc_sh));

    // R9: a one-shot cycle end halts the counter
    a_r9_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.one_shot && tick && q.cnt == q.cyc_act && !wr_en) |=> !running_o);

endmodule

// File: tb/tb_ptm_saw_timer.sv
module tb_ptm_saw_timer;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic out_a, out_b, oe_a, oe_b, running_o, flag_cmp_a, flag_cmp_b, flag_ovf;
    logic [W-1:0] count_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10ns clk = ~clk;

    ptm_saw_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_a(out_a), .out_b(out_b), .oe_a(oe_a), .oe_b(oe_b), .count_o(count_o),
        .running_o(running_o), .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b),
        .flag_ovf(flag_ovf)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int ha, output int hb);
        ha = 0; hb = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ha += int'(out_a);
            hb += int'(out_b);
        end
    endtask

    task automatic measure_period(output int n);
        int guard = 0;
        while (count_o != 0 && guard < 5000) begin @(negedge clk); guard++; end
        n = 0;
        do begin @(negedge clk); n++; end while (count_o != 0 && n < 5000);
    endtask

    task automatic step_len(output int n);
        logic [W-1:0] v;
        int guard = 0;
        v = count_o;
        while (count_o == v && guard < 3000) begin @(negedge clk); guard++; end
        v = count_o;
        n = 0;
        while (count_o == v && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset;
        check(count_o == 0 && !running_o, "R1 counter idle", int'(count_o), 0);
        check(!out_a && !out_b && !oe_a && !oe_b, "R1 outputs off",
              int'({out_a, out_b, oe_a, oe_b}), 0);
        check({flag_ovf, flag_cmp_b, flag_cmp_a} == 3'b000, "R1 flags clear",
              int'({flag_ovf, flag_cmp_b, flag_cmp_a}), 0);
    endtask

    task automatic t_basic;
        int ha, hb, p;
        wr(4'd6, 16'h4646);
        wr(4'd3, 16'd9);
        wr(4'd4, 16'd3);
        wr(4'd5, 16'd6);
        wr(4'd2, 16'h0001);
        idle(12);
        count_high(20, ha, hb);
        check(ha == 12, "R3 code 0x06 high time A", ha, 12);
        check(hb == 6, "R3 code 0x06 high time B", hb, 6);
        measure_period(p);
        check(p == 10, "R6 period N+1", p, 10);
    endtask

    task automatic t_invert_and_stop;
        int ha, hb;
        wr(4'd6, 16'h4659);
        wr(4'd1, 16'h0001);
        idle(12);
        count_high(20, ha, hb);
        check(ha == 8, "R3 code 0x19 high time A", ha, 8);
        wr(4'd1, 16'h0002);
        check(!running_o, "R11 stop command", int'(running_o), 0);
        wr(4'd6, 16'h0079);
        idle(2);
        check(out_a == 1'b1, "R5 stop level driven", int'(out_a), 1);
        check(out_b == 1'b0 && !oe_b, "R5 disabled output low", int'({oe_b, out_b}), 0);
    endtask

    task automatic t_duty;
        int ha, hb;
        wr(4'd6, 16'h4646);
        wr(4'd1, 16'h0001);
        wr(4'd7, 16'h0002);
        idle(3);
        count_high(20, ha, hb);
        check(ha == 0, "R4 forced 0% on A", ha, 0);
        wr(4'd7, 16'h0003);
        idle(3);
        count_high(20, ha, hb);
        check(ha == 20, "R4 forced 100% on A", ha, 20);
        wr(4'd7, 16'h000C);
        idle(3);
        count_high(20, ha, hb);
        check(hb == 20, "R4 forced 100% on B", hb, 20);
        check(ha == 12, "R4 A follows compare again", ha, 12);
        wr(4'd7, 16'h0000);
        wr(4'd1, 16'h0002);
    endtask

    task automatic t_prescale;
        int n;
        wr(4'd2, 16'h0100);
        wr(4'd2, 16'h0101);
        step_len(n);
        check(n == 4, "R2 prescale code 1", n, 4);
        wr(4'd2, 16'h0200);
        wr(4'd2, 16'h0201);
        step_len(n);
        check(n == 16, "R2 prescale code 2", n, 16);
        wr(4'd2, 16'h0500);
        wr(4'd2, 16'h0501);
        step_len(n);
        check(n == 1024, "R2 prescale code 5", n, 1024);
        wr(4'd2, 16'h0000);
    endtask

    task automatic t_buffer;
        int mx, guard;
        wr(4'd1, 16'h0004);
        wr(4'd2, 16'h0001);
        guard = 0;
        while (count_o != 2 && guard < 100) begin @(negedge clk); guard++; end
        wr(4'd3, 16'd4);
        mx = 0; guard = 0;
        while (count_o != 0 && guard < 100) begin
            if (int'(count_o) > mx) mx = int'(count_o);
            @(negedge clk); guard++;
        end
        check(mx == 9, "R10 running cycle kept until wrap", mx, 9);
        mx = 0;
        do begin @(negedge clk); if (int'(count_o) > mx) mx = int'(count_o); end
        while (count_o != 0 && mx < 100);
        check(mx == 4, "R10 new cycle after wrap", mx, 4);
        wr(4'd1, 16'h0002);
        wr(4'd3, 16'd9);
    endtask

    task automatic t_flags;
        idle(2);
        check({flag_ovf, flag_cmp_b, flag_cmp_a} == 3'b111, "R7 flags set",
              int'({flag_ovf, flag_cmp_b, flag_cmp_a}), 7);
        wr(4'd8, 16'h0006);
        check({flag_ovf, flag_cmp_b, flag_cmp_a} == 3'b110, "R7 clear only A",
              int'({flag_ovf, flag_cmp_b, flag_cmp_a}), 6);
        wr(4'd8, 16'h0000);
        check({flag_ovf, flag_cmp_b, flag_cmp_a} == 3'b000, "R7 clear all",
              int'({flag_ovf, flag_cmp_b, flag_cmp_a}), 0);
    endtask

    task automatic t_protect;
        int p;
        wr(4'd0, 16'hA501);
        wr(4'd3, 16'd4);
        wr(4'd0, 16'h0000);
        wr(4'd3, 16'd4);
        wr(4'd1, 16'h0001);
        check(running_o == 1'b1, "R8 command allowed while protected", int'(running_o), 1);
        measure_period(p);
        check(p == 10, "R8 cycle write blocked", p, 10);
        wr(4'd1, 16'h0002);
        wr(4'd8, 16'h0000);
        check(!flag_ovf, "R8 status write allowed", int'(flag_ovf), 0);
        wr(4'd0, 16'hA500);
        wr(4'd3, 16'd4);
        wr(4'd1, 16'h0001);
        measure_period(p);
        check(p == 5, "R8 cycle write after unlock", p, 5);
        wr(4'd1, 16'h0002);
    endtask

    task automatic t_oneshot;
        wr(4'd8, 16'h0000);
        wr(4'd6, 16'h0066);
        wr(4'd2, 16'h0010);
        wr(4'd1, 16'h0005);
        idle(20);
        check(!running_o && count_o == 0, "R9 one-shot halted at 0", int'(count_o), 0);
        check(flag_ovf && flag_cmp_a, "R9 one cycle completed",
              int'({flag_ovf, flag_cmp_a}), 3);
        check(out_a == 1'b1, "R9 output at stop level", int'(out_a), 1);
    endtask

    task automatic t_clear;
        wr(4'd2, 16'h0000);
        wr(4'd3, 16'd9);
        wr(4'd1, 16'h0001);
        idle(3);
        wr(4'd1, 16'h0002);
        check(count_o != 0, "R11 count held when stopped", int'(count_o), 1);
        wr(4'd1, 16'h0004);
        check(count_o == 0, "R11 clear command", int'(count_o), 0);
        wr(4'd1, 16'h0003);
        check(!running_o, "R11 stop wins over start", int'(running_o), 0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_basic();
        t_invert_and_stop();
        t_duty();
        t_prescale();
        t_buffer();
        t_flags();
        t_protect();
        t_oneshot();
        t_clear();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule